// File: doc/BRIEF.md
# Chained Partial-Sum Adder with Final Rounding

This block is the summation backbone of a systolic FIR filter built from several multiply-add slices. Each slice receives four signed products, reduces them to one 44-bit local sum, and adds that sum to the running total handed down from the slice above. The total is registered in every slice, so it moves one slice per clock. No adder tree is needed outside the slices. The top slice can take its running total from an upstream block, or it can drop that contribution under a registered zero control.

Next to the sum chain, each slice has a one-cycle delay register for the cascaded input sample. This keeps the sample scan path in step with the one-cycle latency that each slice adds to the sum. Only the last slice's total reaches the final stage. The final stage can round (half up) or truncate at a configurable bit position. It then either saturates to the output width and raises an overflow flag, or wraps. The raw last-slice total is also brought out, so that a further block can continue the chain.

Top module: `sumchain_fir_stage`

## Requirements
- R1: Each slice adds its four sign-extended products to its chain input and registers the result one clock later. Slice 0 takes `chain_in_i` as its chain input, slice k takes slice k-1's register, and `chain_o` is the last slice's register.
- R2: Products presented to slice k in cycle t+k all belong to the same output. Their total appears on `chain_o` NUM_SLICES clock edges after cycle t, and on `result_o` one edge later.
- R3: `zero_chain_i` is registered once. When it is 1 in cycle t, slice 0 ignores `chain_in_i` when it forms its register at the edge that ends cycle t+1.
- R4: `samp_o` slice k field (bits k*SAMP_W upward) equals `samp_i` delayed by k+1 clock cycles.
- R5: With `round_en_i`=1, the final stage adds 2^(DROP_W-1) to the last-slice total and then shifts it arithmetically right by DROP_W. With `round_en_i`=0, it only shifts, which gives the floor.
- R6: With `sat_en_i`=1, a shifted value above 2^(OUT_W-1)-1 or below -2^(OUT_W-1) is clamped to that limit, and `ovf_o` is 1 in the same cycle as the clamped `result_o`. In-range values give `ovf_o`=0.
- R7: With `sat_en_i`=0, `result_o` is the low OUT_W bits of the shifted value, and `ovf_o` stays 0.
- R8: While `rst_n` is 0 at a clock edge, every register clears: `chain_o`, `samp_o`, `result_o` and `ovf_o` read 0 whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| prod_i | input | NUM_SLICES*PRODS*PROD_W | Signed products; slice s, product i at bits (s*PRODS+i)*PROD_W upward |
| chain_in_i | input | ACC_W | Running total arriving from an upstream block |
| zero_chain_i | input | 1 | 1 drops `chain_in_i` from the sum (registered) |
| samp_i | input | SAMP_W | Cascaded input sample entering the delay path |
| round_en_i | input | 1 | 1 selects round-half-up, 0 selects truncation |
| sat_en_i | input | 1 | 1 selects saturation, 0 selects wrap |
| chain_o | output | ACC_W | Registered total of the last slice |
| samp_o | output | NUM_SLICES*SAMP_W | Delayed samples, one field per slice boundary |
| result_o | output | OUT_W | Rounded and limited filter output |
| ovf_o | output | 1 | Saturation happened on this output |

## Verification
The bench builds the block with three slices of four 36-bit products, a 44-bit chain, an 18-bit sample path, an 8-bit drop and a 16-bit output. With these values the skewed three-slice alignment and the one-cycle lead of the zero control can be observed on `chain_o` edge by edge. A 16-bit output after an 8-bit drop puts both clamp limits at totals near 2^23, so the exact half-LSB boundaries around each limit can be driven through `chain_in_i` alone. Rounding and truncation are compared at values that differ only in the half-LSB bit, for both signs.

// File: rtl/sumchain_pkg.sv
// Package: shared types for the chained partial-sum adder.
// Assumes: nothing beyond a packed struct of final-stage controls.
package sumchain_pkg;

    // Mode controls taken by the final rounding and limiting stage.
    typedef struct packed {
        logic rnd;  // 1: round half up, 0: truncate
        logic sat;  // 1: clamp to output range, 0: wrap
    } fin_ctrl_t;

endpackage

// File: rtl/psum_slice.sv
// Module: psum_slice
// One summation slice. Sign-extends PRODS products, reduces them to a
// local sum, adds the incoming chain value (unless clr_i), and registers the
// total. Also carries the cascaded sample through one delay register.
// Assumes: ACC_W > PROD_W; products are two's complement.
module psum_slice #(
    parameter int PRODS  = 4,
    parameter int PROD_W = 36,
    parameter int ACC_W  = 44,
    parameter int SAMP_W = 18
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PRODS*PROD_W-1:0] prod_i,
    input  logic                    clr_i,
    input  logic [ACC_W-1:0]        chain_i,
    output logic [ACC_W-1:0]        chain_o,
    input  logic [SAMP_W-1:0]       samp_i,
    output logic [SAMP_W-1:0]       samp_o
);

    localparam int EXT_W = ACC_W - PROD_W;

    logic [ACC_W-1:0] prod_ext [PRODS];
    logic [ACC_W-1:0] psum;
    logic [ACC_W-1:0] chain_add;
    logic [ACC_W-1:0] chain_q;
    logic [SAMP_W-1:0] samp_q;

    // Sign-extend each product to the accumulator width.
    for (genvar g = 0; g < PRODS; g++) begin : g_ext
        assign prod_ext[g] = {{EXT_W{prod_i[g*PROD_W+PROD_W-1]}},
                              prod_i[g*PROD_W +: PROD_W]};
    end

    // First adder: local sum of all products of this slice.
    always_comb begin
        psum = '0;
        for (int i = 0; i < PRODS; i++) begin
            psum = psum + prod_ext[i];
        end
    end

    // Second adder: local sum plus chain input, chain dropped on clear.
    always_comb begin
        chain_add = psum + (clr_i ? '0 : chain_i);
    end

    // Chain register: moves the running total one slice per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_add;
    end

    // Sample delay register: keeps the scan path aligned with the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) samp_q <= '0;
        else        samp_q <= samp_i;
    end

    assign chain_o = chain_q;
    assign samp_o  = samp_q;

    // R1: chain register holds local sum plus chain input of the prior cycle
    p_chain_accum_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> chain_o == $past(psum) + $past(chain_i));

    // R3: with clear active the chain input has no part in the total
    p_clr_drops_chain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> chain_o == $past(psum));

    // R4: sample leaves exactly one cycle after it entered
    p_samp_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> samp_o == $past(samp_i));

endmodule

// File: rtl/round_sat_stage.sv
// Module: round_sat_stage
// Final stage of the chain. Optionally adds half an LSB at bit DROP_W-1,
// drops DROP_W low bits arithmetically, then clamps to OUT_W bits with an
// overflow flag or wraps. Output is registered.
// Assumes: DROP_W >= 1 and ACC_W + 1 - DROP_W >= OUT_W.
module round_sat_stage
    import sumchain_pkg::*;
#(
    parameter int ACC_W  = 44,
    parameter int DROP_W = 8,
    parameter int OUT_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] acc_i,
    input  fin_ctrl_t        ctrl_i,
    output logic [OUT_W-1:0] result_o,
    output logic             ovf_o
);

    localparam int EXT_W = ACC_W + 1;
    localparam int PAD_W = EXT_W - OUT_W + 1;
    localparam logic signed [EXT_W-1:0] HALF  = EXT_W'(1) << (DROP_W - 1);
    localparam logic signed [EXT_W-1:0] LIM_HI = {{PAD_W{1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [EXT_W-1:0] LIM_LO = {{PAD_W{1'b1}}, {(OUT_W-1){1'b0}}};
    localparam logic [OUT_W-1:0] MAX_O = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] MIN_O = {1'b1, {(OUT_W-1){1'b0}}};

    logic signed [EXT_W-1:0] ext;
    logic signed [EXT_W-1:0] shifted;
    logic [OUT_W-1:0]        res_d;
    logic                    ovf_d;
    logic [OUT_W-1:0]        res_q;
    logic                    ovf_q;

    // Widen by one bit and add the rounding constant when enabled.
    always_comb begin
        ext = $signed({acc_i[ACC_W-1], acc_i});
        if (ctrl_i.rnd) ext = ext + HALF;
        shifted = ext >>> DROP_W;
    end

    // Clamp or wrap the shifted value to the output width.
    always_comb begin
        res_d = shifted[OUT_W-1:0];
        ovf_d = 1'b0;
        if (ctrl_i.sat && shifted > LIM_HI) begin
            res_d = MAX_O;
            ovf_d = 1'b1;
        end else if (ctrl_i.sat && shifted < LIM_LO) begin
            res_d = MIN_O;
            ovf_d = 1'b1;
        end
    end

    // Output register for result and overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            res_q <= res_d;
            ovf_q <= ovf_d;
        end
    end

    assign result_o = res_q;
    assign ovf_o    = ovf_q;

    // R6: an overflow always comes with a value sitting on a clamp limit
    p_ovf_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (result_o == MAX_O || result_o == MIN_O));

    // R7: wrap mode never reports overflow
    p_wrap_no_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_i.sat |=> !ovf_o);

endmodule

// File: rtl/sumchain_fir_stage.sv
// Module: sumchain_fir_stage (top)
// Chain of NUM_SLICES summation slices. The registered zero control drops
// the upstream chain input at the top slice, and the last total feeds the
// rounding and limiting stage.
// Assumes: the caller skews products to slice k by k cycles.
module sumchain_fir_stage
    import sumchain_pkg::*;
#(
    parameter int NUM_SLICES = 3,
    parameter int PRODS      = 4,
    parameter int PROD_W     = 36,
    parameter int ACC_W      = 44,
    parameter int SAMP_W     = 18,
    parameter int OUT_W      = 16,
    parameter int DROP_W     = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_SLICES*PRODS*PROD_W-1:0] prod_i,
    input  logic [ACC_W-1:0]                   chain_in_i,
    input  logic                               zero_chain_i,
    input  logic [SAMP_W-1:0]                  samp_i,
    input  logic                               round_en_i,
    input  logic                               sat_en_i,
    output logic [ACC_W-1:0]                   chain_o,
    output logic [NUM_SLICES*SAMP_W-1:0]       samp_o,
    output logic [OUT_W-1:0]                   result_o,
    output logic                               ovf_o
);

    localparam int SLICE_PW = PRODS * PROD_W;
    localparam int LAST     = NUM_SLICES - 1;

    logic             zero_q;
    logic [ACC_W-1:0]  chain_w [NUM_SLICES];
    logic [SAMP_W-1:0] samp_w  [NUM_SLICES];
    fin_ctrl_t         ctrl;

    // Register the zero-chain control ahead of the top slice.
    always_ff @(posedge clk) begin
        if (!rst_n) zero_q <= 1'b0;
        else        zero_q <= zero_chain_i;
    end

    // Build the slice chain; slice 0 takes the upstream value.
    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        logic [ACC_W-1:0]  cin;
        logic [SAMP_W-1:0] sin;
        logic              clr;
        if (s == 0) begin : g_top
            assign cin = chain_in_i;
            assign sin = samp_i;
            assign clr = zero_q;
        end else begin : g_mid
            assign cin = chain_w[s-1];
            assign sin = samp_w[s-1];
            assign clr = 1'b0;
        end
        psum_slice #(
            .PRODS  (PRODS),
            .PROD_W (PROD_W),
            .ACC_W  (ACC_W),
            .SAMP_W (SAMP_W)
        ) i_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .prod_i  (prod_i[s*SLICE_PW +: SLICE_PW]),
            .clr_i   (clr),
            .chain_i (cin),
            .chain_o (chain_w[s]),
            .samp_i  (sin),
            .samp_o  (samp_w[s])
        );
        assign samp_o[s*SAMP_W +: SAMP_W] = samp_w[s];
    end

    // Pack the final-stage mode controls.
    always_comb begin
        ctrl.rnd = round_en_i;
        ctrl.sat = sat_en_i;
    end

    round_sat_stage #(
        .ACC_W  (ACC_W),
        .DROP_W (DROP_W),
        .OUT_W  (OUT_W)
    ) i_final (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_i    (chain_w[LAST]),
        .ctrl_i   (ctrl),
        .result_o (result_o),
        .ovf_o    (ovf_o)
    );

    assign chain_o = chain_w[LAST];

    // R3: zero control reaches the top slice exactly one cycle late
    p_zero_reg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> zero_q == $past(zero_chain_i));

endmodule

// File: tb/test_sumchain_fir_stage.sv
// Directed bench for sumchain_fir_stage: one task per scenario.
module test_sumchain_fir_stage;

    localparam int NS     = 3;
    localparam int PRODS  = 4;
    localparam int PROD_W = 36;
    localparam int ACC_W  = 44;
    localparam int SAMP_W = 18;
    localparam int OUT_W  = 16;
    localparam int DROP_W = 8;

    logic                          clk;
    logic                          rst_n;
    logic [NS*PRODS*PROD_W-1:0]    prod;
    logic [ACC_W-1:0]              chain_in;
    logic                          zero_chain;
    logic [SAMP_W-1:0]             samp;
    logic                          round_en;
    logic                          sat_en;
    logic [ACC_W-1:0]              chain_out;
    logic [NS*SAMP_W-1:0]          samp_out;
    logic [OUT_W-1:0]              result;
    logic                          ovf;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    sumchain_fir_stage #(
        .NUM_SLICES (NS),
        .PRODS      (PRODS),
        .PROD_W     (PROD_W),
        .ACC_W      (ACC_W),
        .SAMP_W     (SAMP_W),
        .OUT_W      (OUT_W),
        .DROP_W     (DROP_W)
    ) i_sumchain_fir_stage (
        .clk          (clk),
        .rst_n        (rst_n),
        .prod_i       (prod),
        .chain_in_i   (chain_in),
        .zero_chain_i (zero_chain),
        .samp_i       (samp),
        .round_en_i   (round_en),
        .sat_en_i     (sat_en),
        .chain_o      (chain_out),
        .samp_o       (samp_out),
        .result_o     (result),
        .ovf_o        (ovf)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: run exceeded cycle limit");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint chain_val();
        return longint'($signed(chain_out));
    endfunction

    function automatic longint res_val();
        return longint'($signed(result));
    endfunction

    // Independent model of the final stage.
    task automatic model(input longint s, input bit rnd, input bit sat,
                         output longint r, output bit ov);
        longint t;
        longint hi;
        longint lo;
        t  = s + (rnd ? (64'sd1 <<< (DROP_W - 1)) : 64'sd0);
        t  = t >>> DROP_W;
        hi = (64'sd1 <<< (OUT_W - 1)) - 1;
        lo = -hi - 1;
        ov = 1'b0;
        r  = t;
        if (sat && t > hi) begin r = hi; ov = 1'b1; end
        else if (sat && t < lo) begin r = lo; ov = 1'b1; end
        else if (!sat) begin
            r = t & ((64'sd1 <<< OUT_W) - 1);
            if (r > hi) r = r - (64'sd1 <<< OUT_W);
        end
    endtask

    task automatic set_p(input int s, input int i, input longint v);
        prod[(s*PRODS+i)*PROD_W +: PROD_W] = v[PROD_W-1:0];
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R8: reset clears everything while inputs are busy.
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int s = 0; s < NS; s++)
            for (int i = 0; i < PRODS; i++) set_p(s, i, 1000 + s*10 + i);
        chain_in = 44'd77777;
        samp = 18'h2AAAA;
        wait_edges(3);
        check("R8", "chain_o in reset", chain_val(), 0);
        check("R8", "result_o in reset", res_val(), 0);
        check("R8", "ovf_o in reset", longint'(ovf), 0);
        check("R8", "samp_o in reset", longint'(samp_out), 0);
        prod = '0; chain_in = '0; samp = '0;
        rst_n = 1'b1;
        wait_edges(6);
    endtask

    // R1, R2: steady product patterns give the full sum on chain and output.
    task automatic t_steady(input longint base, input longint cin);
        longint sum;
        longint r;
        bit     ov;
        sum = cin;
        for (int s = 0; s < NS; s++)
            for (int i = 0; i < PRODS; i++) begin
                longint v = ((i % 2) == 0) ? base * (s + i + 1) : -base * (i + 2*s);
                set_p(s, i, v);
                sum = sum + v;
            end
        chain_in = cin[ACC_W-1:0];
        wait_edges(NS + 3);
        model(sum, round_en, sat_en, r, ov);
        check("R1", "chain_o steady sum", chain_val(), sum);
        check("R2", "result_o steady sum", res_val(), r);
        prod = '0; chain_in = '0;
        wait_edges(NS + 2);
    endtask

    // R2: skewed impulse per slice lines up at one edge only.
    task automatic t_latency();
        longint r;
        bit     ov;
        longint v0 = 3000;
        longint v1 = -700;
        longint v2 = 12345;
        set_p(0, 1, v0);
        wait_edges(1);
        set_p(0, 1, 0); set_p(1, 2, v1);
        wait_edges(1);
        check("R2", "chain_o before alignment edge", chain_val(), 0);
        set_p(1, 2, 0); set_p(2, 3, v2);
        wait_edges(1);
        check("R2", "chain_o at alignment edge", chain_val(), v0 + v1 + v2);
        set_p(2, 3, 0);
        wait_edges(1);
        check("R2", "chain_o after alignment edge", chain_val(), 0);
        model(v0 + v1 + v2, round_en, sat_en, r, ov);
        check("R2", "result_o one edge after chain", res_val(), r);
        wait_edges(NS + 2);
    endtask

    // R3: zero control drops the upstream value one cycle late.
    task automatic t_zero();
        longint sum = 0;
        longint cin = 50000;
        longint r;
        bit     ov;
        for (int s = 0; s < NS; s++) begin
            set_p(s, 0, 100 * (s + 1));
            sum = sum + 100 * (s + 1);
        end
        chain_in = cin[ACC_W-1:0];
        wait_edges(NS + 3);
        check("R3", "chain_o with chain input", chain_val(), sum + cin);
        zero_chain = 1'b1;
        wait_edges(NS);
        check("R3", "chain_o before zero takes effect", chain_val(), sum + cin);
        wait_edges(1);
        check("R3", "chain_o after zero", chain_val(), sum);
        wait_edges(1);
        model(sum, round_en, sat_en, r, ov);
        check("R3", "result_o after zero", res_val(), r);
        zero_chain = 1'b0;
        prod = '0; chain_in = '0;
        wait_edges(NS + 3);
    endtask

    // R4: samples step one slice boundary per cycle.
    task automatic t_samp();
        samp = 18'h01234;
        wait_edges(1);
        check("R4", "slice0 sample delay 1", longint'(samp_out[0 +: SAMP_W]), 18'h01234);
        samp = 18'h3ABCD;
        wait_edges(1);
        check("R4", "slice0 sample delay 1", longint'(samp_out[0 +: SAMP_W]), 18'h3ABCD);
        check("R4", "slice1 sample delay 2", longint'(samp_out[SAMP_W +: SAMP_W]), 18'h01234);
        samp = 18'h00F0F;
        wait_edges(1);
        check("R4", "slice2 sample delay 3", longint'(samp_out[2*SAMP_W +: SAMP_W]), 18'h01234);
        check("R4", "slice1 sample delay 2", longint'(samp_out[SAMP_W +: SAMP_W]), 18'h3ABCD);
        samp = '0;
        wait_edges(NS + 1);
    endtask

    // Drive a total through the chain input only and check the final stage.
    task automatic run_final(input string req, input longint s,
                             input bit rnd, input bit sat);
        longint r;
        bit     ov;
        prod = '0;
        chain_in = s[ACC_W-1:0];
        round_en = rnd;
        sat_en = sat;
        wait_edges(NS + 2);
        model(s, rnd, sat, r, ov);
        check(req, $sformatf("result_o total=%0d rnd=%0d sat=%0d", s, rnd, sat), res_val(), r);
        check(req, $sformatf("ovf_o total=%0d rnd=%0d sat=%0d", s, rnd, sat), longint'(ovf), longint'(ov));
    endtask

    // R5: rounding versus truncation at the half-LSB boundary, both signs.
    task automatic t_round();
        run_final("R5", 384, 1'b1, 1'b1);
        run_final("R5", 383, 1'b1, 1'b1);
        run_final("R5", 384, 1'b0, 1'b1);
        run_final("R5", -384, 1'b1, 1'b1);
        run_final("R5", -383, 1'b1, 1'b1);
        run_final("R5", -384, 1'b0, 1'b1);
    endtask

    // R6: saturation limits and overflow flag.
    task automatic t_sat();
        run_final("R6", 8388479, 1'b1, 1'b1);
        run_final("R6", 8388480, 1'b1, 1'b1);
        run_final("R6", -8388608, 1'b1, 1'b1);
        run_final("R6", -8388609, 1'b0, 1'b1);
        run_final("R6", 1000000000, 1'b0, 1'b1);
    endtask

    // R7: wrap mode keeps low bits and never flags overflow.
    task automatic t_wrap();
        run_final("R7", 8388608, 1'b0, 1'b0);
        run_final("R7", -8388609, 1'b0, 1'b0);
        run_final("R7", 1000000000, 1'b1, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0;
        prod = '0;
        chain_in = '0;
        zero_chain = 1'b0;
        samp = '0;
        round_en = 1'b0;
        sat_en = 1'b1;
        t_reset();
        t_steady(1000, 0);
        round_en = 1'b1;
        t_steady(-53211, 987654);
        round_en = 1'b0;
        t_latency();
        t_zero();
        t_samp();
        t_round();
        t_sat();
        t_wrap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule